// File: doc/BRIEF.md
# E1 Intermediate CRC-4 Recalculator

This block is a bit-serial pass-through stage for an E1 stream that is already framed. Timeslot 0 of the incoming stream carries the frame alignment words, the multiframe alignment bits and the CRC-4 check bits. The block lets a host overwrite any of the five spare national bits in the non-alignment frames. It then patches the CRC-4 check bits so that they stay consistent with the new content.

The block does not compute the checksum again from scratch. It runs a CRC-4 over the difference between input and output in each 8-frame half multiframe. That result is XORed into the C bits carried by the following half. Any error syndrome that the incoming checksum already holds therefore survives to the far end.

A multiframe sync pulse, given with the bit enable, marks the first bit of frame 0. Between pulses a free-running position counter keeps track of frame and bit position. The output is always one bit step behind the input, whether the mode is on or off.

Top module: `e1_crc4_recalc`

## Requirements
- R1: After reset `data_o` is 0.
- R2: The bit presented together with `bit_en_i` appears on `data_o` after that clock edge and holds until the next `bit_en_i` edge.
- R3: `mf_sync_i` high with `bit_en_i` marks bit 0 of frame 0. Positions then count 256 bits per frame and 16 frames per multiframe, wrapping freely when no sync arrives. Bit 0 is the first bit sent in a frame.
- R4: When `enable_i` or `crc_ins_i` is low, `data_o` equals the input at every position.
- R5: While active, each Sa bit at bit index 3..7 of an odd frame (Sa4..Sa8 map to `sa_val_i[0]`..`sa_val_i[4]`) is replaced by `sa_val_i` where the matching `sa_mask_i` bit is 1. Where the mask bit is 0, the input bit is kept.
- R6: C bits sit at bit 0 of frames 0, 2, 4 and 6 of each 8-frame half, C1..C4 in that order. C1 is the most significant bit of the CRC remainder. While active, output C = input C XOR the CRC-4 (generator x^4+x+1, message times x^4) of the previous half's input/output difference, with C positions taken as zero.
- R7: Incoming errors survive. Output C bits of half N+1 = CRC(output half N, C zeroed) XOR (input C bits XOR CRC(input half N, C zeroed)).
- R8: All other positions pass unchanged, including the alignment words, the A bit and unmasked Sa bits.
- R9: In the first half multiframe after reset no correction is pending, so the C bits pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One-cycle strobe per line bit |
| data_i | input | 1 | Serial input bit |
| mf_sync_i | input | 1 | Marks first bit of the multiframe (with bit_en_i) |
| enable_i | input | 1 | Recalculation mode enable |
| crc_ins_i | input | 1 | CRC insertion is enabled downstream |
| sa_val_i | input | 5 | Replacement values for Sa4..Sa8 |
| sa_mask_i | input | 5 | Replace masks for Sa4..Sa8 |
| data_o | output | 1 | Serial output bit |

## Verification
Assertions check on every cycle that the output holds between bit strobes and that bypass mode and non-overhead positions copy the input. They also check that masked Sa bits take the host value, that the position counter wraps and resynchronises, and that the pending correction changes only at a half-multiframe boundary. Only the bench scenarios can show that the patched C bits agree with a CRC recomputed from scratch over the output, and that injected checksum errors reach the output intact. The bench scenarios also cover partial masks, toggling of either enable, and resynchronisation after stray bits.

// File: rtl/e1_crc4_pkg.sv
package e1_crc4_pkg;
  localparam int FRAME_BITS = 256;
  localparam int FRAMES_MF  = 16;
  localparam int SMF_FRAMES = 8;
  localparam int CRC_W      = 4;
  localparam int SA_N       = 5;
  localparam int SA_FIRST   = 3;

  localparam int BIT_W     = $clog2(FRAME_BITS);
  localparam int FRM_W     = $clog2(FRAMES_MF);
  localparam int POS_W     = BIT_W + FRM_W;
  localparam int SMF_POS_W = BIT_W + $clog2(SMF_FRAMES);
  localparam int C_IDX_W   = $clog2(CRC_W);
  localparam int SA_IDX_W  = $clog2(SA_N);

  // x^4 + x + 1 without the leading term
  localparam logic [CRC_W-1:0] CRC_POLY = 4'b0011;

  function automatic logic [CRC_W-1:0] crc_step(logic [CRC_W-1:0] r, logic d);
    logic fb;
    fb = d ^ r[CRC_W-1];
    return {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/e1_mf_pos.sv
module e1_mf_pos
  import e1_crc4_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_en_i,
  input  logic                mf_sync_i,
  output logic                smf_start_o,
  output logic                smf_end_o,
  output logic                c_pos_o,
  output logic [C_IDX_W-1:0]  c_idx_o,
  output logic                sa_pos_o,
  output logic [SA_IDX_W-1:0] sa_idx_o
);
  logic [POS_W-1:0] pos_q, cur;
  logic [BIT_W-1:0] bit_n;
  logic [FRM_W-1:0] frm_n;

  assign cur   = mf_sync_i ? '0 : pos_q;
  assign bit_n = cur[BIT_W-1:0];
  assign frm_n = cur[POS_W-1:BIT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pos_q <= '0;
    else if (bit_en_i) pos_q <= cur + POS_W'(1);
  end

  assign smf_start_o = (cur[SMF_POS_W-1:0] == '0);
  assign smf_end_o   = &cur[SMF_POS_W-1:0];
  assign c_pos_o     = !frm_n[0] && (bit_n == '0);
  assign c_idx_o     = frm_n[C_IDX_W:1];
  assign sa_pos_o    = frm_n[0] && (bit_n >= BIT_W'(SA_FIRST))
                       && (bit_n < BIT_W'(SA_FIRST + SA_N));
  assign sa_idx_o    = SA_IDX_W'(bit_n - BIT_W'(SA_FIRST));

  a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i && !mf_sync_i && (&pos_q) |=> pos_q == '0);
  a_r3_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i && mf_sync_i |=> pos_q == POS_W'(1));
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(pos_q));
endmodule

// File: rtl/e1_crc4_diff.sv
module e1_crc4_diff
  import e1_crc4_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             smf_start_i,
  input  logic             smf_end_i,
  input  logic             diff_i,
  output logic [CRC_W-1:0] corr_o
);
  logic [CRC_W-1:0] crc_q, crc_base, crc_nx;

  assign crc_base = smf_start_i ? '0 : crc_q;
  assign crc_nx   = crc_step(crc_base, diff_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q  <= '0;
      corr_o <= '0;
    end else if (bit_en_i) begin
      crc_q <= crc_nx;
      if (smf_end_i) corr_o <= crc_nx;  // applied during the next half
    end
  end

  a_r6_corr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bit_en_i && smf_end_i) |=> $stable(corr_o));
endmodule

// File: rtl/e1_crc4_recalc.sv
module e1_crc4_recalc
  import e1_crc4_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bit_en_i,
  input  logic            data_i,
  input  logic            mf_sync_i,
  input  logic            enable_i,
  input  logic            crc_ins_i,
  input  logic [SA_N-1:0] sa_val_i,
  input  logic [SA_N-1:0] sa_mask_i,
  output logic            data_o
);
  logic                smf_start, smf_end, c_pos, sa_pos, active, sa_repl;
  logic                out_bit, diff;
  logic [C_IDX_W-1:0]  c_idx;
  logic [SA_IDX_W-1:0] sa_idx;
  logic [CRC_W-1:0]    corr;

  e1_mf_pos u_pos (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_en_i    (bit_en_i),
    .mf_sync_i   (mf_sync_i),
    .smf_start_o (smf_start),
    .smf_end_o   (smf_end),
    .c_pos_o     (c_pos),
    .c_idx_o     (c_idx),
    .sa_pos_o    (sa_pos),
    .sa_idx_o    (sa_idx)
  );

  assign active  = enable_i & crc_ins_i;
  assign sa_repl = active && sa_pos && sa_mask_i[sa_idx];

  always_comb begin
    if (active && c_pos) out_bit = data_i ^ corr[~c_idx];  // C1 is the MSB
    else if (sa_repl)    out_bit = sa_val_i[sa_idx];
    else                 out_bit = data_i;
  end

  // only Sa changes feed the CRC; C positions count as zero
  assign diff = (active && sa_pos) ? (data_i ^ out_bit) : 1'b0;

  e1_crc4_diff u_crc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_en_i    (bit_en_i),
    .smf_start_i (smf_start),
    .smf_end_i   (smf_end),
    .diff_i      (diff),
    .corr_o      (corr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       data_o <= 1'b0;
    else if (bit_en_i) data_o <= out_bit;
  end

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(data_o));
  a_r4_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i && !(enable_i && crc_ins_i) |=> data_o == $past(data_i));
  a_r5_sa_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i && enable_i && crc_ins_i && sa_pos && sa_mask_i[sa_idx]
    |=> data_o == $past(sa_val_i[sa_idx]));
  a_r8_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i && !sa_pos && !c_pos |=> data_o == $past(data_i));
endmodule

// File: tb/e1_crc4_recalc_tb_top.sv
module e1_crc4_recalc_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_en_i = 1'b0, data_i = 1'b0, mf_sync_i = 1'b0;
  logic       enable_i = 1'b0, crc_ins_i = 1'b0;
  logic [4:0] sa_val_i = '0, sa_mask_i = '0;
  logic       data_o;

  always #4 clk_i = ~clk_i;  // 125 MHz

  e1_crc4_recalc dut_i (
    .clk_i, .rst_ni, .bit_en_i, .data_i, .mf_sync_i,
    .enable_i, .crc_ins_i, .sa_val_i, .sa_mask_i, .data_o
  );

  typedef struct { logic exp; string tag; } item_t;
  item_t q[$];
  int errors = 0, checks = 0;
  logic took = 1'b0, last_out = 1'b0;
  logic [3:0] prev_in = '0, prev_out = '0, acc_in = '0, acc_out = '0;
  bit first_half = 1'b1, first_mf = 1'b1;
  int nbit = 0;

  // long division by x^4+x+1 with the remainder in r
  function automatic logic [3:0] div_step(logic [3:0] r, logic b);
    logic [4:0] t;
    t = {r, b};
    if (t[4]) t = t ^ 5'b10011;
    return t[3:0];
  endfunction
  function automatic logic [3:0] div_fin(logic [3:0] r);
    logic [3:0] x;
    x = r;
    for (int i = 0; i < 4; i++) x = div_step(x, 1'b0);
    return x;
  endfunction

  always @(posedge clk_i) took <= bit_en_i;

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && took) begin
      item_t it;
      if (q.size() == 0) begin
        errors++; checks++;
        $display("FAIL R2: output with empty queue, actual=%0b expected=none", data_o);
      end else begin
        it = q.pop_front();
        checks++;
        if (data_o !== it.exp) begin
          errors++;
          $display("FAIL %s: bit %0d actual=%0b expected=%0b", it.tag, nbit, data_o, it.exp);
        end
      end
      last_out = data_o;
      nbit++;
    end else if (rst_ni && nbit > 0 && (nbit % 97) == 0) begin
      checks++;
      if (data_o !== last_out) begin
        errors++;
        $display("FAIL R2: hold actual=%0b expected=%0b", data_o, last_out);
      end
    end
  end

  task automatic send_bit(logic d, logic s, logic e, string tag, int gap);
    item_t it;
    @(negedge clk_i);
    data_i = d; mf_sync_i = s; bit_en_i = 1'b1;
    it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk_i);
    bit_en_i = 1'b0; mf_sync_i = 1'b0;
    repeat (gap) @(negedge clk_i);
  endtask

  task automatic run_mf(logic en, logic ins, logic [4:0] val, logic [4:0] mask,
                        logic [3:0] err0, logic [3:0] err1);
    enable_i = en; crc_ins_i = ins; sa_val_i = val; sa_mask_i = mask;
    for (int p = 0; p < 4096; p++) begin
      int fr, b, k;
      logic [3:0] err;
      logic act, is_c, is_sa, din, e;
      string tag;
      fr = p / 256; b = p % 256; k = (fr % 8) / 2;
      err = (fr >= 8) ? err1 : err0;
      is_c = (fr % 2 == 0) && (b == 0);
      is_sa = (fr % 2 == 1) && (b >= 3) && (b <= 7);
      act = en && ins;
      din = is_c ? (prev_in[3-k] ^ err[3-k]) : 1'($urandom);
      if (act && is_c)                    e = prev_out[3-k] ^ err[3-k];
      else if (act && is_sa && mask[b-3]) e = val[b-3];
      else                                e = din;
      if (!act)            tag = "R4";
      else if (is_c)       tag = first_half ? "R9" : ((err != 0) ? "R7" : "R6");
      else if (is_sa)      tag = first_mf ? "R3" : "R5";
      else                 tag = "R8";
      acc_in  = div_step(acc_in,  is_c ? 1'b0 : din);
      acc_out = div_step(acc_out, is_c ? 1'b0 : e);
      send_bit(din, p == 0, e, tag, (p % 3 == 0) ? 1 : 0);
      if (b == 255 && (fr % 8) == 7) begin
        prev_in = div_fin(acc_in); prev_out = div_fin(acc_out);
        acc_in = '0; acc_out = '0; first_half = 1'b0;
      end
    end
    first_mf = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if (data_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset actual=%0b expected=0", data_o);
    end
    rst_ni = 1'b1;
    // stray bits before the first sync, mode off
    for (int i = 0; i < 300; i++) begin
      logic d;
      d = 1'($urandom);
      send_bit(d, 1'b0, d, "R4", i % 2);
    end
    run_mf(1'b1, 1'b1, 5'b10110, 5'b11111, 4'h0, 4'h0);
    run_mf(1'b1, 1'b1, 5'b01001, 5'b11111, 4'h5, 4'hA);
    run_mf(1'b1, 1'b0, 5'b11111, 5'b11111, 4'h3, 4'h0);
    run_mf(1'b0, 1'b1, 5'b00000, 5'b11111, 4'h0, 4'h8);
    run_mf(1'b1, 1'b1, 5'b11011, 5'b10101, 4'h0, 4'h0);
    run_mf(1'b1, 1'b1, 5'b11111, 5'b00000, 4'h6, 4'h0);
    run_mf(1'b1, 1'b1, 5'b00100, 5'b11111, 4'hF, 4'h1);
    repeat (4) @(negedge clk_i);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2: leftover actual=%0d expected=0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL R2: watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule